// File: doc/BRIEF.md
# Segmented Page Table Translator

This block turns a virtual address into a physical address. It does not use one linear page table for the whole address space. Instead, each logical segment (code, heap, stack) has its own small page table. The two top bits of the virtual address pick a segment register pair:

- The pair's base value is the physical address where that segment's page table starts.
- The pair's bound value is the number of entries that table holds.

A translation runs in four steps. The block checks the page index against the bound. It fetches one page table entry with a single memory read. It checks the entry's valid, present and permission bits. It then returns either the physical address or a fault with a cause code.

Software loads each segment's base and bound through a register write port. A translation request is accepted only while the block is idle, so at most one translation is in flight at a time. The response is held until the consumer takes it. With the default parameters:

- The virtual address is 14 bits: 2 segment bits, a 2-bit page index and a 10-bit offset, so pages are 1 KB.
- The physical address is 16 bits: a 6-bit physical page number and the unchanged offset.

Top module: `seg_xlate`

## Requirements
- R1: Virtual address bits [13:12] select the segment: 00 code, 01 heap, 11 stack. Code 10 has no table and always answers with a bounds fault without any memory read.
- R2: A cycle with cfg_we high loads cfg_base and cfg_bound into the register pair chosen by cfg_seg (same codes as R1). A write that names code 10 changes nothing.
- R3: If the page index (bits [11:10]) is greater than or equal to the segment's bound, the response is a fault with cause 01 and no memory read is issued. A bound of 0 faults every index.
- R4: Otherwise exactly one memory read is issued, at address base + 4 × index, using a valid/ready request followed by a single data beat flagged by mem_rsp_valid. The address stays stable while it waits for ready.
- R5: The page table entry (PTE) layout is: physical page number in bits [5:0], valid in bit 16, read in bit 17, write in bit 18, execute in bit 19, present in bit 20, dirty in bit 21. The dirty bit has no effect on translation.
- R6: An entry with valid = 0 or present = 0 gives a fault with cause 10.
- R7: A valid, present entry is checked against the access type: 00 read needs the read bit, 01 write needs the write bit, 10 execute needs the execute bit, and 11 is never permitted. A failed check gives a fault with cause 11.
- R8: A successful translation answers with rsp_fault = 0, cause 00 and rsp_paddr = {PPN, offset}, where the offset is virtual address bits [9:0] unchanged.
- R9: Every fault response drives rsp_paddr to 0.
- R10: req_ready is low from the cycle after a request is accepted until the cycle after its response is taken. While rsp_ready is low, rsp_valid and the response fields hold steady.
- R11: After reset: req_ready = 1, rsp_valid = 0, mem_req_valid = 0, and every bound is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 14 | Virtual address to translate |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | 00 none, 01 bounds, 10 invalid entry, 11 protection |
| rsp_paddr | output | 16 | Physical address, or 0 on fault |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_seg | input | 2 | Segment code being written |
| cfg_base | input | 16 | Physical start of the segment's page table |
| cfg_bound | input | 3 | Number of entries in the segment's page table |
| mem_req_valid | output | 1 | Page table entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 16 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page table entry contents |

## Verification
The bench aims at four kinds of corner case.

- **Bound edges.** It uses an index one past the bound, a bound of 0 and an index at the largest full bound. A design that compared with > instead of >= would read an entry past the end of the table. A design that did not compare at all would issue reads for faults that need none.
- **Entry decoding.** It sends entries with only valid cleared, only present cleared, a set dirty bit, and every access type against read-only, read/execute and read/write entries. A design that mixed up bit positions, or the order of the invalid and protection checks, would return the wrong cause.
- **Table pointers.** It moves a segment's base onto another segment's table and checks the fetch address. A design that used the base as a data offset instead of a table pointer would produce the wrong physical page.
- **Handshakes.** It holds off rsp_ready and delays mem_req_ready. A design that took a second request or let the response drift would be caught.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MREQ  = 2'd1,
        ST_MWAIT = 2'd2,
        ST_RESP  = 2'd3
    } xl_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_BOUNDS  = 2'd1,
        CAUSE_INVALID = 2'd2,
        CAUSE_PROT    = 2'd3
    } xl_cause_e;

    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    localparam logic [1:0] SEG_CODE   = 2'b00;
    localparam logic [1:0] SEG_HEAP   = 2'b01;
    localparam logic [1:0] SEG_UNUSED = 2'b10;
    localparam logic [1:0] SEG_STACK  = 2'b11;

    localparam int SEG_W      = 2;
    localparam int SEG_SLOTS  = 4;

    // page table entry flag positions
    localparam int PTE_VALID_BIT   = 16;
    localparam int PTE_READ_BIT    = 17;
    localparam int PTE_WRITE_BIT   = 18;
    localparam int PTE_EXEC_BIT    = 19;
    localparam int PTE_PRESENT_BIT = 20;
    localparam int PTE_DIRTY_BIT   = 21;

endpackage

// File: rtl/seg_regs.sv
module seg_regs
    import seg_xlate_pkg::*;
#(
    parameter int PA_W  = 16,
    parameter int BND_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEG_W-1:0] wseg,
    input  logic [PA_W-1:0]  wbase,
    input  logic [BND_W-1:0] wbound,
    input  logic [SEG_W-1:0] rseg,
    output logic [PA_W-1:0]  rbase,
    output logic [BND_W-1:0] rbound,
    output logic             rseg_ok
);

    logic [SEG_SLOTS-1:0][PA_W-1:0]  base_all;
    logic [SEG_SLOTS-1:0][BND_W-1:0] bound_all;

    for (genvar g = 0; g < SEG_SLOTS; g++) begin : g_slot
        if (g == int'(SEG_UNUSED)) begin : g_hole
            assign base_all[g]  = '0;
            assign bound_all[g] = '0;
        end else begin : g_pair
            logic [PA_W-1:0]  base_d,  base_q;
            logic [BND_W-1:0] bound_d, bound_q;

            always_comb begin
                base_d  = base_q;
                bound_d = bound_q;
                if (we && (wseg == SEG_W'(g))) begin
                    base_d  = wbase;
                    bound_d = wbound;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    base_q  <= '0;
                    bound_q <= '0;
                end else begin
                    base_q  <= base_d;
                    bound_q <= bound_d;
                end
            end

            assign base_all[g]  = base_q;
            assign bound_all[g] = bound_q;
        end
    end

    assign rbase   = base_all[rseg];
    assign rbound  = bound_all[rseg];
    assign rseg_ok = (rseg != SEG_UNUSED);

endmodule

// File: rtl/seg_pte_check.sv
module seg_pte_check
    import seg_xlate_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PPN_W = 6
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       acc,
    output logic [PPN_W-1:0] ppn,
    output xl_cause_e        cause
);

    logic live;
    logic allowed;
    logic unused_pte_bits;

    assign ppn  = pte[PPN_W-1:0];
    assign live = pte[PTE_VALID_BIT] & pte[PTE_PRESENT_BIT];
    // the dirty bit and any spare bits play no part in the decision
    assign unused_pte_bits = ^pte;

    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = pte[PTE_READ_BIT];
            ACC_WRITE: allowed = pte[PTE_WRITE_BIT];
            ACC_EXEC:  allowed = pte[PTE_EXEC_BIT];
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin
        if (!live) begin
            cause = CAUSE_INVALID;
        end else if (!allowed) begin
            cause = CAUSE_PROT;
        end else begin
            cause = CAUSE_NONE;
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 14,
    parameter int OFF_W = 10,
    parameter int PA_W  = 16,
    parameter int PTE_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [VA_W-1:0]           req_vaddr,
    input  logic [1:0]                req_acc,
    output logic                      rsp_valid,
    input  logic                      rsp_ready,
    output logic                      rsp_fault,
    output logic [1:0]                rsp_cause,
    output logic [PA_W-1:0]           rsp_paddr,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_seg,
    input  logic [PA_W-1:0]           cfg_base,
    input  logic [VA_W-OFF_W-2:0]     cfg_bound,
    output logic                      mem_req_valid,
    input  logic                      mem_req_ready,
    output logic [PA_W-1:0]           mem_req_addr,
    input  logic                      mem_rsp_valid,
    input  logic [PTE_W-1:0]          mem_rsp_data
);

    localparam int IDX_W = VA_W - SEG_W - OFF_W;
    localparam int BND_W = IDX_W + 1;
    localparam int PPN_W = PA_W - OFF_W;

    typedef struct packed {
        xl_state_e        state;
        logic [OFF_W-1:0] off;
        logic [1:0]       acc;
        logic [PA_W-1:0]  maddr;
        logic [PA_W-1:0]  paddr;
        xl_cause_e        cause;
    } xl_reg_t;

    xl_reg_t xl_d, xl_q;

    logic [SEG_W-1:0] req_seg;
    logic [IDX_W-1:0] req_idx;
    logic [PA_W-1:0]  seg_base;
    logic [BND_W-1:0] seg_bound;
    logic             seg_ok;
    logic [PPN_W-1:0] pte_ppn;
    xl_cause_e        pte_cause;

    assign req_seg = req_vaddr[VA_W-1 -: SEG_W];
    assign req_idx = req_vaddr[OFF_W +: IDX_W];

    seg_regs #(
        .PA_W  (PA_W),
        .BND_W (BND_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wseg    (cfg_seg),
        .wbase   (cfg_base),
        .wbound  (cfg_bound),
        .rseg    (req_seg),
        .rbase   (seg_base),
        .rbound  (seg_bound),
        .rseg_ok (seg_ok)
    );

    seg_pte_check #(
        .PTE_W (PTE_W),
        .PPN_W (PPN_W)
    ) u_pte (
        .pte   (mem_rsp_data),
        .acc   (xl_q.acc),
        .ppn   (pte_ppn),
        .cause (pte_cause)
    );

    always_comb begin
        xl_d = xl_q;
        unique case (xl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    xl_d.off = req_vaddr[OFF_W-1:0];
                    xl_d.acc = req_acc;
                    if (!seg_ok || ({1'b0, req_idx} >= seg_bound)) begin
                        xl_d.cause = CAUSE_BOUNDS;
                        xl_d.paddr = '0;
                        xl_d.state = ST_RESP;
                    end else begin
                        xl_d.maddr = seg_base + (PA_W'(req_idx) << 2);
                        xl_d.state = ST_MREQ;
                    end
                end
            end
            ST_MREQ: begin
                if (mem_req_ready) begin
                    xl_d.state = ST_MWAIT;
                end
            end
            ST_MWAIT: begin
                if (mem_rsp_valid) begin
                    xl_d.cause = pte_cause;
                    xl_d.paddr = (pte_cause == CAUSE_NONE) ? {pte_ppn, xl_q.off} : '0;
                    xl_d.state = ST_RESP;
                end
            end
            ST_RESP: begin
                if (rsp_ready) begin
                    xl_d.state = ST_IDLE;
                end
            end
            default: xl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xl_q <= '{state: ST_IDLE, off: '0, acc: '0, maddr: '0, paddr: '0, cause: CAUSE_NONE};
        end else begin
            xl_q <= xl_d;
        end
    end

    assign req_ready     = (xl_q.state == ST_IDLE);
    assign mem_req_valid = (xl_q.state == ST_MREQ);
    assign mem_req_addr  = xl_q.maddr;
    assign rsp_valid     = (xl_q.state == ST_RESP);
    assign rsp_cause     = xl_q.cause;
    assign rsp_fault     = (xl_q.cause != CAUSE_NONE);
    assign rsp_paddr     = xl_q.paddr;

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int PA_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic            rsp_fault,
    input logic [1:0]      rsp_cause,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr
);

    // R10: a pending response keeps new requests out
    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R10: idle, fetching and answering never overlap
    a_r10_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_req_valid, rsp_valid}));

    // R10: a stalled response holds its contents
    a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_cause) && $stable(rsp_fault)));

    // R4: a stalled entry read keeps its address
    a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R4: an accepted entry read is never repeated on the next cycle
    a_r4_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    // R9: faults never expose an address
    a_r9_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R8: success carries cause 00, faults a non-zero cause
    a_r8_cause_match: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_cause     (rsp_cause),
    .rsp_paddr     (rsp_paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;
    logic [15:0] rsp_paddr;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_seg = '0;
    logic [15:0] cfg_base = '0;
    logic [2:0]  cfg_bound = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;

    always #5 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_vaddr (req_vaddr), .req_acc (req_acc),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
        .rsp_fault (rsp_fault), .rsp_cause (rsp_cause), .rsp_paddr (rsp_paddr),
        .cfg_we (cfg_we), .cfg_seg (cfg_seg), .cfg_base (cfg_base), .cfg_bound (cfg_bound),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // memory model
    logic [31:0] mem [0:255];
    int          mem_lat = 0;
    int          reads = 0;
    logic [15:0] last_addr = '0;
    logic [15:0] seg_base_ref [0:3];

    initial begin
        int wait_cnt;
        logic [15:0] cap;
        wait_cnt = 0;
        cap = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                last_addr     = cap;
                reads++;
                mem_rsp_data  = mem[cap[9:2]];
                mem_rsp_valid = 1'b1;
            end else if (mem_req_valid) begin
                if (wait_cnt >= mem_lat) begin
                    mem_req_ready = 1'b1;
                    cap = mem_req_addr;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    function automatic logic [31:0] pte(input logic [5:0] ppn, input bit v, input bit r,
                                        input bit w, input bit x, input bit p, input bit d);
        logic [31:0] e;
        e = '0;
        e[5:0] = ppn;
        e[16] = v; e[17] = r; e[18] = w; e[19] = x; e[20] = p; e[21] = d;
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] s, input logic [15:0] b, input logic [2:0] n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_seg = s; cfg_base = b; cfg_bound = n;
        @(negedge clk);
        cfg_we = 1'b0;
        if (s != 2'b10) seg_base_ref[s] = b;
    endtask

    logic        got_fault;
    logic [1:0]  got_cause;
    logic [15:0] got_paddr;
    int          got_reads;
    bit          busy_ok;
    bit          hold_ok;

    task automatic xlate(input logic [13:0] va, input logic [1:0] acc, input int hold);
        int r0;
        r0 = reads;
        busy_ok = 1'b1;
        hold_ok = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        got_fault = rsp_fault; got_cause = rsp_cause; got_paddr = rsp_paddr;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            if (!rsp_valid || req_ready || rsp_paddr != got_paddr || rsp_cause != got_cause)
                hold_ok = 1'b0;
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        got_reads = reads - r0;
    endtask

    // {vaddr[13:0], acc[1:0], cause[1:0], paddr[15:0]}
    localparam int NV = 16;
    localparam logic [33:0] VEC [NV] = '{
        {2'b00, 2'd0, 10'h155, 2'd2, 2'd0, 16'h2955},  // code exec ok
        {2'b00, 2'd1, 10'h3FF, 2'd0, 2'd0, 16'h5FFF},  // code read ok, top offset
        {2'b00, 2'd1, 10'h000, 2'd1, 2'd3, 16'h0000},  // code write: protection
        {2'b00, 2'd2, 10'h000, 2'd0, 2'd1, 16'h0000},  // code index == bound
        {2'b01, 2'd0, 10'h001, 2'd1, 2'd0, 16'hA001},  // heap write ok, dirty set
        {2'b01, 2'd0, 10'h001, 2'd2, 2'd3, 16'h0000},  // heap exec: protection
        {2'b01, 2'd1, 10'h010, 2'd0, 2'd2, 16'h0000},  // heap valid clear
        {2'b01, 2'd2, 10'h010, 2'd0, 2'd2, 16'h0000},  // heap present clear
        {2'b01, 2'd3, 10'h010, 2'd0, 2'd1, 16'h0000},  // heap index == bound
        {2'b10, 2'd0, 10'h000, 2'd0, 2'd1, 16'h0000},  // unused segment code
        {2'b11, 2'd3, 10'h000, 2'd0, 2'd0, 16'hB400},  // stack last entry
        {2'b11, 2'd2, 10'h200, 2'd1, 2'd0, 16'hDE00},  // stack write ok
        {2'b11, 2'd1, 10'h000, 2'd1, 2'd3, 16'h0000},  // read-only page, write
        {2'b11, 2'd1, 10'h0AA, 2'd0, 2'd0, 16'h30AA},  // read-only page, read
        {2'b11, 2'd0, 10'h000, 2'd0, 2'd2, 16'h0000},  // stack invalid entry
        {2'b00, 2'd0, 10'h000, 2'd3, 2'd3, 16'h0000}   // access code 11
    };

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < 4; i++) seg_base_ref[i] = '0;
        // code table at 0x100
        mem[64]  = pte(6'd10, 1, 1, 0, 1, 1, 0);
        mem[65]  = pte(6'd23, 1, 1, 0, 1, 1, 0);
        // heap table at 0x200
        mem[128] = pte(6'd40, 1, 1, 1, 0, 1, 1);
        mem[129] = pte(6'd33, 0, 1, 1, 0, 1, 0);
        mem[130] = pte(6'd7,  1, 1, 1, 0, 0, 0);
        // stack table at 0x300
        mem[192] = pte(6'd60, 0, 1, 1, 1, 0, 0);
        mem[193] = pte(6'd12, 1, 1, 0, 0, 1, 0);
        mem[194] = pte(6'd55, 1, 1, 1, 0, 1, 1);
        mem[195] = pte(6'd45, 1, 1, 1, 0, 1, 0);

        repeat (3) @(negedge clk);
        // R11: reset state
        chk(req_ready == 1'b1, "R11 req_ready after reset", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R11 rsp_valid after reset", 32'(rsp_valid), 0);
        chk(mem_req_valid == 1'b0, "R11 mem_req_valid after reset", 32'(mem_req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R11/R2: bounds reset to zero
        xlate({2'b00, 2'd0, 10'h0}, 2'd0, 0);
        chk(got_cause == 2'd1 && got_reads == 0, "R11 zero bound after reset",
            {got_reads[15:0], 14'd0, got_cause}, 32'd1);

        cfg(2'b00, 16'h0100, 3'd2);
        cfg(2'b01, 16'h0200, 3'd3);
        cfg(2'b11, 16'h0300, 3'd4);

        for (int i = 0; i < NV; i++) begin
            logic [13:0] va;
            logic [1:0]  ac, ec;
            logic [15:0] ep;
            {va, ac, ec, ep} = VEC[i];
            xlate(va, ac, 0);
            chk(got_cause == ec, "R1 R3 R6 R7 cause", 32'(got_cause), 32'(ec));
            chk(got_fault == (ec != 2'd0), "R8 fault flag", 32'(got_fault), 32'(ec != 2'd0));
            chk(got_paddr == ep, "R8 R9 paddr", 32'(got_paddr), 32'(ep));
            if (ec == 2'd1) begin
                chk(got_reads == 0, "R3 no read on bounds fault", got_reads, 0);
            end else begin
                chk(got_reads == 1, "R4 one read", got_reads, 1);
                chk(last_addr == seg_base_ref[va[13:12]] + 16'(va[11:10]) * 16'd4,
                    "R4 entry address", 32'(last_addr),
                    32'(seg_base_ref[va[13:12]] + 16'(va[11:10]) * 16'd4));
            end
            chk(busy_ok, "R10 no ready while busy", 32'(busy_ok), 1);
        end

        // R10: response held while stalled
        xlate({2'b11, 2'd3, 10'h123}, 2'd1, 5);
        chk(hold_ok, "R10 response hold", 32'(hold_ok), 1);
        chk(got_paddr == 16'hB523, "R10 held paddr", 32'(got_paddr), 32'hB523);

        // R4: slow memory ready
        mem_lat = 3;
        xlate({2'b11, 2'd2, 10'h3C0}, 2'd0, 0);
        chk(got_paddr == 16'hDFC0 && got_reads == 1, "R4 delayed ready",
            32'(got_paddr), 32'hDFC0);
        mem_lat = 0;

        // R1/R2: write to unused code is ignored
        cfg(2'b10, 16'h0300, 3'd4);
        xlate({2'b10, 2'd3, 10'h0}, 2'd0, 0);
        chk(got_cause == 2'd1 && got_reads == 0, "R2 unused slot write ignored",
            32'(got_cause), 32'd1);

        // R3: bound of zero faults index 0
        cfg(2'b00, 16'h0100, 3'd0);
        xlate({2'b00, 2'd0, 10'h0}, 2'd2, 0);
        chk(got_cause == 2'd1 && got_reads == 0, "R3 zero bound", 32'(got_cause), 32'd1);

        // R2/R4: heap base moved onto stack table
        cfg(2'b01, 16'h0300, 3'd4);
        xlate({2'b01, 2'd3, 10'h004}, 2'd0, 0);
        chk(got_paddr == 16'hB404 && last_addr == 16'h030C, "R2 base is table pointer",
            32'(got_paddr), 32'hB404);

        // R5: dirty bit has no effect
        mem[195] = pte(6'd45, 1, 1, 1, 0, 1, 1);
        xlate({2'b11, 2'd3, 10'h000}, 2'd1, 0);
        chk(got_cause == 2'd0 && got_paddr == 16'hB400, "R5 dirty ignored",
            32'(got_paddr), 32'hB400);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule